// File: doc/BRIEF.md
# Priority-Deferred Instruction Issue Buffer

This block sits between the decoder and the single functional unit of a single-issue, in-order core. Each decoded instruction carries a one-bit priority tag set by the compiler. Urgent instructions are loads, branches and the instructions that produce their operands. They issue straight away. Every other instruction is parked in a reorder buffer and never holds up the pipeline. The parked work is released onto the issue port while a cache miss is outstanding, so that the miss latency does useful work. A flush command releases everything still parked, for example at a loop exit.

The block keeps a per-register account of the parked instructions. Each register has three counts: parked writers, parked readers of the architectural copy, and parked readers of a shadow copy. An urgent instruction is held back when any of the following applies:
- it touches a register that a parked instruction still has to write;
- it touches the register whose load is currently missing;
- it would overwrite a register that parked instructions still read.

In the last case the block first injects a move. The move copies the register into its shadow rename register, and the parked readers are redirected to that shadow. Each architectural register has one shadow. A second overwrite therefore waits until the earlier shadow readers have drained. While an urgent instruction is held back, parked work drains so that the hold always resolves.

Top module: `priority_defer_issue`

## Requirements
- R1: After reset, no instruction is issued (`iss_valid`=0), `in_ready` is 1 and the buffer is empty.
- R2: An urgent instruction (`in_prio`=1) with no hazard is accepted in the same cycle. One cycle later it appears on the issue port with kind 0 (direct) and its opcode and register fields unchanged, with both shadow flags 0.
- R3: A deferrable instruction (`in_prio`=0) arriving while the buffer has room is always accepted (`in_ready`=1). It is held in the buffer. Nothing parked issues while there is no miss, no flush and no held-back instruction.
- R4: While `miss_pending` is 1, parked instructions issue with kind 1 (deferred), at most one per cycle, oldest first.
- R5: An urgent instruction that can issue takes the issue port ahead of parked work in that cycle. The parked work follows in the next free cycle.
- R6: While `miss_pending` is 1, the following are held:
  - an urgent instruction whose source or destination equals `miss_reg` is held (`in_ready`=0);
  - the oldest parked instruction, if it reads the architectural `miss_reg` or writes it, is not drained.
- R7: An urgent instruction that reads or writes a register written by a parked instruction is held. Parked work drains one per cycle until the hazard clears, and the instruction then issues.
- R8: An urgent instruction whose destination D is read by parked instructions through the architectural copy is held for one cycle. In that cycle a move issues with kind 2, opcode 0, destination D and sources D, both shadow flags 0. Those parked readers later issue with their shadow flag for D set to 1.
- R9: If the shadow of D is still read by parked instructions when a new move for D is needed, the urgent instruction is held. Parked work drains until the shadow is free, then the move issues.
- R10: A one-cycle `flush` pulse drains every parked instruction, one per cycle in age order, after `flush` returns to 0, until the buffer is empty.
- R11: A deferrable instruction arriving while the buffer holds DEPTH entries is issued directly (kind 0) under the same hazard rules as an urgent one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_prio | input | 1 | 1 = urgent, 0 = deferrable |
| in_op | input | OPW | Opcode |
| in_dst | input | RW | Destination register |
| in_src0 | input | RW | First source register |
| in_src1 | input | RW | Second source register |
| in_ready | output | 1 | Instruction taken this cycle |
| miss_pending | input | 1 | A cache miss is outstanding |
| miss_reg | input | RW | Register the missing load will fill |
| flush | input | 1 | Drain all parked instructions |
| iss_valid | output | 1 | Issue slot carries an operation |
| iss_kind | output | 2 | 0 direct, 1 deferred, 2 move |
| iss_op | output | OPW | Issued opcode |
| iss_dst | output | RW | Issued destination |
| iss_src0 | output | RW | Issued first source |
| iss_src0_shadow | output | 1 | First source reads the shadow copy |
| iss_src1 | output | RW | Issued second source |
| iss_src1_shadow | output | 1 | Second source reads the shadow copy |

## Verification
The bench builds the block with a four-entry buffer, eight registers and four-bit opcodes. With only eight registers, every destination/source pattern of an urgent instruction can be swept against every possible missing register, and against a parked writer. With four entries, the full-buffer bypass, oldest-first draining across pointer wrap and the shadow reuse stall are all reached in a few dozen cycles.

// File: rtl/ipb_pkg.sv
package ipb_pkg;
  typedef enum logic [1:0] {
    KIND_DIRECT = 2'd0,
    KIND_DEFER  = 2'd1,
    KIND_MOVE   = 2'd2
  } iss_kind_e;
endpackage

// File: rtl/ipb_store.sv
// Circular store of parked instructions with per-source shadow flags.
module ipb_store #(
  parameter int DEPTH = 100,
  parameter int OPW   = 8,
  parameter int RW    = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enq,
  input  logic [OPW-1:0] enq_op,
  input  logic [RW-1:0]  enq_dst,
  input  logic [RW-1:0]  enq_src0,
  input  logic [RW-1:0]  enq_src1,
  input  logic           deq,
  input  logic           mv_en,
  input  logic [RW-1:0]  mv_reg,
  output logic [OPW-1:0] hd_op,
  output logic [RW-1:0]  hd_dst,
  output logic [RW-1:0]  hd_src0,
  output logic           hd_ren0,
  output logic [RW-1:0]  hd_src1,
  output logic           hd_ren1,
  output logic           empty,
  output logic           full,
  output logic           one_left
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [OPW-1:0] op_q   [DEPTH];
  logic [RW-1:0]  dst_q  [DEPTH];
  logic [RW-1:0]  s0_q   [DEPTH];
  logic [RW-1:0]  s1_q   [DEPTH];
  logic           ren0_q [DEPTH];
  logic           ren1_q [DEPTH];

  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = enq ? step_ptr(wr_q) : wr_q;
    rd_d  = deq ? step_ptr(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (enq && !deq) cnt_d = cnt_q + 1'b1;
    else if (!enq && deq) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Entry storage: written on enqueue, shadow flags set by a move.
  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (enq && wr_q == PW'(e)) begin
        op_q[e]   <= enq_op;
        dst_q[e]  <= enq_dst;
        s0_q[e]   <= enq_src0;
        s1_q[e]   <= enq_src1;
        ren0_q[e] <= 1'b0;
        ren1_q[e] <= 1'b0;
      end else if (mv_en) begin
        if (s0_q[e] == mv_reg) ren0_q[e] <= 1'b1;
        if (s1_q[e] == mv_reg) ren1_q[e] <= 1'b1;
      end
    end
  end

  assign hd_op    = op_q[rd_q];
  assign hd_dst   = dst_q[rd_q];
  assign hd_src0  = s0_q[rd_q];
  assign hd_ren0  = ren0_q[rd_q];
  assign hd_src1  = s1_q[rd_q];
  assign hd_ren1  = ren1_q[rd_q];
  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign one_left = (cnt_q == CW'(1));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    enq |-> (!full || deq));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    deq |-> !empty);
endmodule

// File: rtl/ipb_regtrack.sv
// Per-register counts of parked writers, architectural readers and shadow readers.
module ipb_regtrack #(
  parameter int DEPTH = 100,
  parameter int RW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq,
  input  logic [RW-1:0] enq_dst,
  input  logic [RW-1:0] enq_src0,
  input  logic [RW-1:0] enq_src1,
  input  logic          deq,
  input  logic [RW-1:0] deq_dst,
  input  logic [RW-1:0] deq_src0,
  input  logic          deq_ren0,
  input  logic [RW-1:0] deq_src1,
  input  logic          deq_ren1,
  input  logic          mv_en,
  input  logic [RW-1:0] mv_reg,
  input  logic [RW-1:0] q_dst,
  input  logic [RW-1:0] q_src0,
  input  logic [RW-1:0] q_src1,
  output logic          q_written,
  output logic          q_arch_rd_dst,
  output logic          q_shadow_dst
);
  localparam int NREG = 1 << RW;
  localparam int CW   = $clog2(2 * DEPTH + 1);

  logic [CW-1:0] wcnt_q [NREG];
  logic [CW-1:0] wcnt_d [NREG];
  logic [CW-1:0] acnt_q [NREG];
  logic [CW-1:0] acnt_d [NREG];
  logic [CW-1:0] scnt_q [NREG];
  logic [CW-1:0] scnt_d [NREG];

  always_comb begin
    wcnt_d = wcnt_q;
    acnt_d = acnt_q;
    scnt_d = scnt_q;
    if (enq) begin
      wcnt_d[enq_dst]  = wcnt_d[enq_dst] + CW'(1);
      acnt_d[enq_src0] = acnt_d[enq_src0] + CW'(1);
      acnt_d[enq_src1] = acnt_d[enq_src1] + CW'(1);
    end
    if (deq) begin
      wcnt_d[deq_dst] = wcnt_d[deq_dst] - CW'(1);
      if (deq_ren0) scnt_d[deq_src0] = scnt_d[deq_src0] - CW'(1);
      else          acnt_d[deq_src0] = acnt_d[deq_src0] - CW'(1);
      if (deq_ren1) scnt_d[deq_src1] = scnt_d[deq_src1] - CW'(1);
      else          acnt_d[deq_src1] = acnt_d[deq_src1] - CW'(1);
    end
    if (mv_en) begin
      scnt_d[mv_reg] = acnt_d[mv_reg];
      acnt_d[mv_reg] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        wcnt_q[r] <= '0;
        acnt_q[r] <= '0;
        scnt_q[r] <= '0;
      end
    end else if (enq || deq || mv_en) begin
      wcnt_q <= wcnt_d;
      acnt_q <= acnt_d;
      scnt_q <= scnt_d;
    end
  end

  assign q_written = (wcnt_q[q_dst] != '0) || (wcnt_q[q_src0] != '0) ||
                     (wcnt_q[q_src1] != '0);
  assign q_arch_rd_dst = (acnt_q[q_dst] != '0);
  assign q_shadow_dst  = (scnt_q[q_dst] != '0);

  assert_shadow_free_on_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mv_en |-> (scnt_q[mv_reg] == '0));
  assert_drain_has_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    deq |-> (wcnt_q[deq_dst] != '0));
endmodule

// File: rtl/priority_defer_issue.sv
module priority_defer_issue
  import ipb_pkg::*;
#(
  parameter int DEPTH = 100,
  parameter int RW    = 4,
  parameter int OPW   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_prio,
  input  logic [OPW-1:0] in_op,
  input  logic [RW-1:0]  in_dst,
  input  logic [RW-1:0]  in_src0,
  input  logic [RW-1:0]  in_src1,
  output logic           in_ready,
  input  logic           miss_pending,
  input  logic [RW-1:0]  miss_reg,
  input  logic           flush,
  output logic           iss_valid,
  output logic [1:0]     iss_kind,
  output logic [OPW-1:0] iss_op,
  output logic [RW-1:0]  iss_dst,
  output logic [RW-1:0]  iss_src0,
  output logic           iss_src0_shadow,
  output logic [RW-1:0]  iss_src1,
  output logic           iss_src1_shadow
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic [OPW-1:0] hd_op;
  logic [RW-1:0]  hd_dst, hd_src0, hd_src1;
  logic           hd_ren0, hd_ren1, empty, full, one_left;
  logic           q_written, q_arch_rd_dst, q_shadow_dst;
  logic           go_direct, go_defer, miss_hit, direct_ok, held;
  logic           issue_dir, issue_mv, head_blk, drain;
  logic           flush_act_q, flush_act_d, empty_next;

  // Selection between immediate issue and parking.
  assign go_direct = in_valid && (in_prio || full);
  assign go_defer  = in_valid && !in_prio && !full;
  assign miss_hit  = miss_pending && ((in_src0 == miss_reg) ||
                     (in_src1 == miss_reg) || (in_dst == miss_reg));
  assign direct_ok = !q_written && !miss_hit && !q_arch_rd_dst;
  assign held      = go_direct && !direct_ok;
  assign issue_dir = go_direct && direct_ok;
  assign issue_mv  = go_direct && q_arch_rd_dst && !q_shadow_dst;
  assign head_blk  = miss_pending && ((!hd_ren0 && hd_src0 == miss_reg) ||
                     (!hd_ren1 && hd_src1 == miss_reg) || (hd_dst == miss_reg));
  assign drain     = !empty && !head_blk && !issue_dir && !issue_mv &&
                     (miss_pending || flush || flush_act_q || held);
  assign in_ready  = !go_direct || direct_ok;

  assign empty_next  = (empty && !go_defer) || (one_left && drain && !go_defer);
  assign flush_act_d = (flush || flush_act_q) && !empty_next;

  ipb_store #(.DEPTH(DEPTH), .OPW(OPW), .RW(RW)) i_store (
    .clk(clk), .rst_n(rst_i),
    .enq(go_defer), .enq_op(in_op), .enq_dst(in_dst),
    .enq_src0(in_src0), .enq_src1(in_src1),
    .deq(drain), .mv_en(issue_mv), .mv_reg(in_dst),
    .hd_op(hd_op), .hd_dst(hd_dst), .hd_src0(hd_src0), .hd_ren0(hd_ren0),
    .hd_src1(hd_src1), .hd_ren1(hd_ren1),
    .empty(empty), .full(full), .one_left(one_left)
  );

  ipb_regtrack #(.DEPTH(DEPTH), .RW(RW)) i_track (
    .clk(clk), .rst_n(rst_i),
    .enq(go_defer), .enq_dst(in_dst), .enq_src0(in_src0), .enq_src1(in_src1),
    .deq(drain), .deq_dst(hd_dst), .deq_src0(hd_src0), .deq_ren0(hd_ren0),
    .deq_src1(hd_src1), .deq_ren1(hd_ren1),
    .mv_en(issue_mv), .mv_reg(in_dst),
    .q_dst(in_dst), .q_src0(in_src0), .q_src1(in_src1),
    .q_written(q_written), .q_arch_rd_dst(q_arch_rd_dst),
    .q_shadow_dst(q_shadow_dst)
  );

  // Issue slot next-state.
  iss_kind_e      kind_d, kind_q;
  logic           vld_d, vld_q, sh0_d, sh0_q, sh1_d, sh1_q;
  logic [OPW-1:0] op_d, op_q;
  logic [RW-1:0]  dst_d, dst_q, s0_d, s0_q, s1_d, s1_q;

  always_comb begin
    vld_d  = issue_dir || issue_mv || drain;
    kind_d = KIND_DIRECT;
    op_d   = in_op;
    dst_d  = in_dst;
    s0_d   = in_src0;
    s1_d   = in_src1;
    sh0_d  = 1'b0;
    sh1_d  = 1'b0;
    if (issue_mv) begin
      kind_d = KIND_MOVE;
      op_d   = '0;
      s0_d   = in_dst;
      s1_d   = in_dst;
    end else if (drain) begin
      kind_d = KIND_DEFER;
      op_d   = hd_op;
      dst_d  = hd_dst;
      s0_d   = hd_src0;
      s1_d   = hd_src1;
      sh0_d  = hd_ren0;
      sh1_d  = hd_ren1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      vld_q       <= 1'b0;
      flush_act_q <= 1'b0;
    end else begin
      vld_q       <= vld_d;
      flush_act_q <= flush_act_d;
    end
  end

  always_ff @(posedge clk) begin
    if (vld_d) begin
      kind_q <= kind_d;
      op_q   <= op_d;
      dst_q  <= dst_d;
      s0_q   <= s0_d;
      s1_q   <= s1_d;
      sh0_q  <= sh0_d;
      sh1_q  <= sh1_d;
    end
  end

  assign iss_valid       = vld_q;
  assign iss_kind        = kind_q;
  assign iss_op          = op_q;
  assign iss_dst         = dst_q;
  assign iss_src0        = s0_q;
  assign iss_src0_shadow = sh0_q;
  assign iss_src1        = s1_q;
  assign iss_src1_shadow = sh1_q;

  assert_low_never_waits_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (in_valid && !in_prio && !full) |-> in_ready);
  assert_direct_clear_of_miss_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (iss_valid && iss_kind == KIND_DIRECT) |->
      !($past(miss_pending) && ($past(miss_reg) == iss_src0 ||
        $past(miss_reg) == iss_src1 || $past(miss_reg) == iss_dst)));
  assert_defer_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (iss_valid && iss_kind == KIND_DEFER) |->
      $past(miss_pending || flush || flush_act_q || (in_valid && !in_ready)));
  assert_move_copies_self_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (iss_valid && iss_kind == KIND_MOVE) |->
      (iss_dst == iss_src0 && !iss_src0_shadow && !iss_src1_shadow));
endmodule

// File: tb/test_priority_defer_issue.sv
module test_priority_defer_issue;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_prio = 1'b0;
  logic [3:0] in_op = '0;
  logic [2:0] in_dst = '0, in_src0 = '0, in_src1 = '0;
  logic       in_ready;
  logic       miss_pending = 1'b0;
  logic [2:0] miss_reg = '0;
  logic       flush = 1'b0;
  logic       iss_valid, iss_src0_shadow, iss_src1_shadow;
  logic [1:0] iss_kind;
  logic [3:0] iss_op;
  logic [2:0] iss_dst, iss_src0, iss_src1;

  int vectors = 0;
  int errors  = 0;
  logic       a_rdy, a_v, a_sh0, a_sh1;
  logic [1:0] a_k;
  logic [3:0] a_op;
  logic [2:0] a_d, a_s0, a_s1;

  always #2 clk = ~clk;

  priority_defer_issue #(.DEPTH(4), .RW(3), .OPW(4)) i_priority_defer_issue (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_prio(in_prio), .in_op(in_op), .in_dst(in_dst),
    .in_src0(in_src0), .in_src1(in_src1), .in_ready(in_ready),
    .miss_pending(miss_pending), .miss_reg(miss_reg), .flush(flush),
    .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_src0(iss_src0), .iss_src0_shadow(iss_src0_shadow),
    .iss_src1(iss_src1), .iss_src1_shadow(iss_src1_shadow)
  );

  // One cycle: drive, sample ready before the edge, sample the issue slot after it.
  task automatic cyc(input logic v, input logic p, input logic [3:0] op,
                     input logic [2:0] d, input logic [2:0] s0, input logic [2:0] s1,
                     input logic mp, input logic [2:0] mr, input logic fl);
    in_valid = v; in_prio = p; in_op = op; in_dst = d; in_src0 = s0; in_src1 = s1;
    miss_pending = mp; miss_reg = mr; flush = fl;
    #1;
    a_rdy = in_ready;
    @(posedge clk);
    #1;
    a_v = iss_valid; a_k = iss_kind; a_op = iss_op; a_d = iss_dst;
    a_s0 = iss_src0; a_sh0 = iss_src0_shadow; a_s1 = iss_src1; a_sh1 = iss_src1_shadow;
  endtask

  task automatic idle(input logic mp, input logic [2:0] mr, input logic fl);
    cyc(1'b0, 1'b0, 4'd0, 3'd0, 3'd0, 3'd0, mp, mr, fl);
  endtask

  task automatic chk(input string req, input logic rdy, input logic v,
                     input logic [1:0] k, input logic [3:0] op, input logic [2:0] d,
                     input logic [2:0] s0, input logic sh0, input logic [2:0] s1,
                     input logic sh1);
    logic [18:0] act, exp;
    act = {a_rdy, a_v, a_k, a_op, a_d, a_s0, a_sh0, a_s1, a_sh1};
    exp = {rdy, v, k, op, d, s0, sh0, s1, sh1};
    if (!v) begin
      act[16:0] = '0;
      exp[16:0] = '0;
    end
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got rdy/v/kind/op/dst/s0/sh0/s1/sh1 = %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1: watchdog expired, actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1: reset state
    idle(1'b0, 3'd0, 1'b0);
    chk("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0);

    // R2: urgent instructions issue directly, fields unchanged
    for (int d = 0; d < 8; d++) begin
      for (int s = 0; s < 8; s++) begin
        logic [2:0] s1v;
        logic [3:0] opv;
        s1v = 3'((d + s) % 8);
        opv = 4'((d * 3 + s) % 16);
        cyc(1, 1, opv, 3'(d), 3'(s), s1v, 0, 0, 0);
        chk("R2", 1, 1, 2'd0, opv, 3'(d), 3'(s), 0, s1v, 0);
      end
    end

    // R6: urgent instruction against every missing register
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 8; s++) begin
        logic [2:0] dv, s1v;
        logic hit;
        dv  = 3'((s + 3) % 8);
        s1v = 3'((s + 1) % 8);
        hit = (m == s) || (3'(m) == s1v) || (3'(m) == dv);
        cyc(1, 1, 4'd6, dv, 3'(s), s1v, 1, 3'(m), 0);
        if (hit) chk("R6", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        else     chk("R6", 1, 1, 2'd0, 4'd6, dv, 3'(s), 0, s1v, 0);
      end
    end

    // R3 / R4 / R6 / R10: park three, drain under miss, head blocked, flush the rest
    cyc(1, 0, 4'd5, 3'd1, 3'd2, 3'd3, 0, 0, 0);
    chk("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 4'd6, 3'd4, 3'd5, 3'd6, 0, 0, 0);
    chk("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 4'd7, 3'd7, 3'd0, 3'd0, 0, 0, 0);
    chk("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(0, 0, 0);
    chk("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(0, 0, 0);
    chk("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(1, 3'd7, 0);
    chk("R4", 1, 1, 2'd1, 4'd5, 3'd1, 3'd2, 0, 3'd3, 0);
    idle(1, 3'd7, 0);
    chk("R4", 1, 1, 2'd1, 4'd6, 3'd4, 3'd5, 0, 3'd6, 0);
    idle(1, 3'd7, 0);
    chk("R6", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(0, 0, 0);
    chk("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(0, 0, 1);
    chk("R10", 1, 1, 2'd1, 4'd7, 3'd7, 3'd0, 0, 3'd0, 0);
    idle(0, 0, 0);
    chk("R10", 1, 0, 0, 0, 0, 0, 0, 0, 0);

    // R5: urgent wins the port during a miss, parked work follows
    cyc(1, 0, 4'd5, 3'd1, 3'd2, 3'd3, 0, 0, 0);
    chk("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 4'd4, 3'd4, 3'd5, 3'd5, 1, 3'd6, 0);
    chk("R5", 1, 1, 2'd0, 4'd4, 3'd4, 3'd5, 0, 3'd5, 0);
    idle(1, 3'd6, 0);
    chk("R5", 1, 1, 2'd1, 4'd5, 3'd1, 3'd2, 0, 3'd3, 0);
    idle(0, 0, 0);
    chk("R5", 1, 0, 0, 0, 0, 0, 0, 0, 0);

    // R7: read of a register a parked instruction writes
    for (int s = 0; s < 8; s++) begin
      cyc(1, 0, 4'd11, 3'd5, 3'd5, 3'd5, 0, 0, 0);
      chk("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc(1, 1, 4'd2, 3'd1, 3'(s), 3'd0, 0, 0, 0);
      if (s == 5) begin
        chk("R7", 0, 1, 2'd1, 4'd11, 3'd5, 3'd5, 0, 3'd5, 0);
        cyc(1, 1, 4'd2, 3'd1, 3'(s), 3'd0, 0, 0, 0);
        chk("R7", 1, 1, 2'd0, 4'd2, 3'd1, 3'(s), 0, 3'd0, 0);
      end else begin
        chk("R7", 1, 1, 2'd0, 4'd2, 3'd1, 3'(s), 0, 3'd0, 0);
        idle(0, 0, 1);
        chk("R10", 1, 1, 2'd1, 4'd11, 3'd5, 3'd5, 0, 3'd5, 0);
      end
    end

    // R8 / R9: move into shadow, redirected readers, shadow reuse stall
    cyc(1, 0, 4'd9, 3'd6, 3'd2, 3'd3, 0, 0, 0);
    chk("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 4'd1, 3'd2, 3'd4, 3'd4, 0, 0, 0);
    chk("R8", 0, 1, 2'd2, 4'd0, 3'd2, 3'd2, 0, 3'd2, 0);
    cyc(1, 1, 4'd1, 3'd2, 3'd4, 3'd4, 0, 0, 0);
    chk("R8", 1, 1, 2'd0, 4'd1, 3'd2, 3'd4, 0, 3'd4, 0);
    cyc(1, 0, 4'd10, 3'd7, 3'd2, 3'd2, 0, 0, 0);
    chk("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 4'd3, 3'd2, 3'd4, 3'd4, 0, 0, 0);
    chk("R9", 0, 1, 2'd1, 4'd9, 3'd6, 3'd2, 1, 3'd3, 0);
    cyc(1, 1, 4'd3, 3'd2, 3'd4, 3'd4, 0, 0, 0);
    chk("R9", 0, 1, 2'd2, 4'd0, 3'd2, 3'd2, 0, 3'd2, 0);
    cyc(1, 1, 4'd3, 3'd2, 3'd4, 3'd4, 0, 0, 0);
    chk("R9", 1, 1, 2'd0, 4'd3, 3'd2, 3'd4, 0, 3'd4, 0);
    idle(0, 0, 1);
    chk("R8", 1, 1, 2'd1, 4'd10, 3'd7, 3'd2, 1, 3'd2, 1);
    idle(0, 0, 0);
    chk("R10", 1, 0, 0, 0, 0, 0, 0, 0, 0);

    // R11 / R10 / R4: fill, bypass when full, flush drains oldest first
    for (int i = 1; i <= 4; i++) begin
      cyc(1, 0, 4'(i), 3'(i), 3'd0, 3'd0, 0, 0, 0);
      chk("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    end
    cyc(1, 0, 4'd8, 3'd5, 3'd6, 3'd6, 0, 0, 0);
    chk("R11", 1, 1, 2'd0, 4'd8, 3'd5, 3'd6, 0, 3'd6, 0);
    idle(0, 0, 1);
    chk("R10", 1, 1, 2'd1, 4'd1, 3'd1, 3'd0, 0, 3'd0, 0);
    for (int i = 2; i <= 4; i++) begin
      idle(0, 0, 0);
      chk("R10", 1, 1, 2'd1, 4'(i), 3'(i), 3'd0, 0, 3'd0, 0);
    end
    idle(0, 0, 0);
    chk("R10", 1, 0, 0, 0, 0, 0, 0, 0, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule